// File: doc/BRIEF.md
# XTS Tweak Sequence Generator

This block holds the running 128-bit tweak of an XTS stream and hands out the whitening values for a whole group of 16-byte blocks at once. The caller first loads the starting tweak, which is the IV already encrypted under the tweak key. The block then presents a group of `VECS` vectors with `LANES` 128-bit lanes each. Lane `n` of the group (counting vector-major) holds the current tweak multiplied by x^n in GF(2^128).

An advance request carries a step count k and multiplies the stored tweak by x^k in a single cycle. A count of 1 moves forward by one block. A count equal to the group size (`LANES*VECS`) refills the whole group for the next batch of blocks. The stored tweak is always visible on a readback port, so a later run can resume where this one stopped.

A new load wins over an advance presented in the same cycle. A step count outside 1..16 is rejected with a one-cycle error pulse and leaves the tweak untouched.

Top module: `xts_tweak_gen`

## Requirements
- R1: After reset the stored tweak (`next_tweak_o`), every lane of `lanes_o` and `err_o` are all zero.
- R2: When `load_i` is high at a clock edge, `next_tweak_o` equals `load_tweak_i` from that edge on.
- R3: When `load_i` and `adv_i` are both high at an edge, only the load takes effect and `err_o` stays low in the following cycle.
- R4: A single step (k = 1) treats the tweak as two 64-bit halves, bits [127:64] and [63:0]. Each half is shifted left by one. Bit 63 moves into bit 64. When bit 127 was set, 0x87 is XORed into bits [7:0].
- R5: An advance with a valid count k (1 to 16) replaces the stored tweak with the result of k single steps, in one cycle.
- R6: An advance whose count is 0 or above 16 (and that is not overruled by a load) raises `err_o` for exactly the next cycle and leaves `next_tweak_o` unchanged.
- R7: Lane n of `lanes_o` occupies bits [128n+127:128n] and equals `next_tweak_o` advanced by n single steps, for n from 0 to `LANES*VECS-1`.
- R8: An advance by `LANES*VECS` steps makes the new lane 0 equal to the old highest lane advanced by one step, so consecutive groups cover consecutive blocks.
- R9: A multi-step advance stays correct when several of the top k bits of both halves are set at once, including a carry out of bit 127.
- R10: With neither `load_i` nor `adv_i` high, `next_tweak_o` keeps its value and `err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load a new starting tweak |
| load_tweak_i | input | 128 | Starting tweak (encrypted IV) |
| adv_i | input | 1 | Advance request |
| adv_steps_i | input | 5 | Number of steps k; valid range 1 to 16 |
| lanes_o | output | 128*LANES*VECS | Tweaks for the current group, lane n at bits [128n+127:128n] |
| next_tweak_o | output | 128 | Stored tweak, for readback and resume |
| err_o | output | 1 | One-cycle pulse after a rejected step count |

## Verification
The hardest case to reach from the ports is a multi-step jump where the top k bits of both halves carry set bits at the same moment. In that case the folded reduction product and the bits that cross from the low half into the high half must both land correctly in one cycle. The stimulus loads tweaks with dense upper bits in each half, such as all ones and alternating patterns, and then jumps by 7, 13, 16 and the group size. The results are compared against a model that shifts the full 128-bit value one bit at a time. Rejected counts are driven right after a known load, so an unwanted change would show up on the readback port.

// File: rtl/xts_tg_pkg.sv
package xts_tg_pkg;

  typedef logic [127:0] tweak_t;
  typedef logic [63:0]  half_t;

  localparam half_t RED_POLY = 64'h87;

  // One multiply by x, done on the two 64-bit halves.
  function automatic tweak_t step_x(tweak_t t);
    half_t lo;
    half_t hi;
    half_t nlo;
    half_t nhi;
    lo  = t[63:0];
    hi  = t[127:64];
    nhi = {hi[62:0], lo[63]};
    nlo = {lo[62:0], 1'b0} ^ (hi[63] ? RED_POLY : 64'h0);
    return {nhi, nlo};
  endfunction

  // Multiply by x^k in one pass: fold top bits of the high half through
  // the reduction polynomial, move top bits of the low half upward.
  function automatic tweak_t jump_x(tweak_t t, int unsigned k);
    half_t lo;
    half_t hi;
    half_t hi_top;
    half_t lo_top;
    half_t fold;
    if (k == 0) return t;
    lo     = t[63:0];
    hi     = t[127:64];
    hi_top = hi >> (64 - k);
    lo_top = lo >> (64 - k);
    fold   = '0;
    for (int b = 0; b < 57; b++) begin
      if (hi_top[b]) fold = fold ^ (RED_POLY << b);
    end
    return {(hi << k) | lo_top, (lo << k) ^ fold};
  endfunction

endpackage

// File: rtl/xts_tg_step_ctrl.sv
module xts_tg_step_ctrl #(
  parameter int MAX_STEP = 16,
  parameter int STEP_W   = 5
) (
  input  logic              load_req,
  input  logic              adv_req,
  input  logic [STEP_W-1:0] steps,
  output logic              do_load,
  output logic              do_adv,
  output logic              bad_adv
);
  logic range_ok;

  always_comb begin
    range_ok = (steps != '0) && (steps <= STEP_W'(MAX_STEP));
    do_load  = load_req;
    do_adv   = adv_req && !load_req && range_ok;
    bad_adv  = adv_req && !load_req && !range_ok;
  end
endmodule

// File: rtl/xts_tg_jump.sv
module xts_tg_jump
  import xts_tg_pkg::*;
#(
  parameter int STEP_W = 5
) (
  input  tweak_t            cur,
  input  logic [STEP_W-1:0] k,
  output tweak_t            nxt
);
  always_comb begin
    nxt = jump_x(cur, 32'(k));
  end
endmodule

// File: rtl/xts_tg_lane_fan.sv
module xts_tg_lane_fan
  import xts_tg_pkg::*;
#(
  parameter int LANES = 4,
  parameter int VECS  = 4,
  localparam int NL   = LANES * VECS
) (
  input  tweak_t               base,
  output logic [NL*128-1:0]    lanes
);
  generate
    if (LANES == 1) begin : g_serial
      // One lane per vector: a plain chain of single steps is cheapest.
      tweak_t chain [NL];
      assign chain[0] = base;
      for (genvar n = 1; n < NL; n++) begin : g_chain
        assign chain[n] = step_x(chain[n-1]);
      end
      for (genvar n = 0; n < NL; n++) begin : g_out
        assign lanes[n*128 +: 128] = chain[n];
      end
    end else begin : g_parallel
      // Wide vectors: each lane is an independent jump from the base.
      for (genvar v = 0; v < VECS; v++) begin : g_vec
        for (genvar l = 0; l < LANES; l++) begin : g_lane
          localparam int N = v * LANES + l;
          assign lanes[N*128 +: 128] = jump_x(base, N);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xts_tweak_gen.sv
module xts_tweak_gen
  import xts_tg_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int VECS     = 4,
  parameter int MAX_STEP = 16,
  localparam int NL      = LANES * VECS,
  localparam int STEP_W  = $clog2(MAX_STEP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [127:0]        load_tweak_i,
  input  logic                adv_i,
  input  logic [STEP_W-1:0]   adv_steps_i,
  output logic [NL*128-1:0]   lanes_o,
  output logic [127:0]        next_tweak_o,
  output logic                err_o
);
  tweak_t tweak_q;
  tweak_t jumped;
  logic   evt_load;
  logic   evt_adv_ok;
  logic   evt_adv_bad;

  xts_tg_step_ctrl #(.MAX_STEP(MAX_STEP), .STEP_W(STEP_W)) u_ctrl (
    .load_req (load_i),
    .adv_req  (adv_i),
    .steps    (adv_steps_i),
    .do_load  (evt_load),
    .do_adv   (evt_adv_ok),
    .bad_adv  (evt_adv_bad)
  );

  xts_tg_jump #(.STEP_W(STEP_W)) u_jump (
    .cur (tweak_q),
    .k   (adv_steps_i),
    .nxt (jumped)
  );

  xts_tg_lane_fan #(.LANES(LANES), .VECS(VECS)) u_fan (
    .base  (tweak_q),
    .lanes (lanes_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tweak_q <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= evt_adv_bad;
      if (evt_load)        tweak_q <= load_tweak_i;
      else if (evt_adv_ok) tweak_q <= jumped;
    end
  end

  assign next_tweak_o = tweak_q;
endmodule

// File: rtl/xts_tweak_gen_chk.sv
module xts_tweak_gen_chk #(
  parameter int STEP_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic [127:0]      load_tweak_i,
  input logic              adv_i,
  input logic [STEP_W-1:0] adv_steps_i,
  input logic [127:0]      lane1,
  input logic [127:0]      next_tweak_o,
  input logic              err_o,
  input logic              evt_adv_ok,
  input logic              evt_adv_bad
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> next_tweak_o == $past(load_tweak_i)); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && adv_i) |=> !err_o); // R3
  AST_ONE_STEP_MATCHES_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_adv_ok && adv_steps_i == STEP_W'(1)) |=> next_tweak_o == $past(lane1)); // R5
  AST_BAD_KEEPS_TWEAK: assert property (@(posedge clk) disable iff (!rst_n)
    evt_adv_bad |=> ($stable(next_tweak_o) && err_o)); // R6
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($past(adv_i) && !$past(load_i))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> ($stable(next_tweak_o) && !err_o)); // R10
endmodule

bind xts_tweak_gen xts_tweak_gen_chk #(.STEP_W(STEP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_i       (load_i),
  .load_tweak_i (load_tweak_i),
  .adv_i        (adv_i),
  .adv_steps_i  (adv_steps_i),
  .lane1        (lanes_o[255:128]),
  .next_tweak_o (next_tweak_o),
  .err_o        (err_o),
  .evt_adv_ok   (evt_adv_ok),
  .evt_adv_bad  (evt_adv_bad)
);

// File: tb/xts_tweak_gen_bench.sv
module xts_tweak_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int VECS  = 4;
  localparam int NL    = LANES * VECS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_i = 1'b0;
  logic [127:0]      load_tweak_i = '0;
  logic              adv_i = 1'b0;
  logic [4:0]        adv_steps_i = '0;
  logic [NL*128-1:0] lanes_o;
  logic [127:0]      next_tweak_o;
  logic              err_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xts_tweak_gen #(.LANES(LANES), .VECS(VECS)) u_xts_tweak_gen (
    .clk (clk), .rst_n (rst_n), .load_i (load_i), .load_tweak_i (load_tweak_i),
    .adv_i (adv_i), .adv_steps_i (adv_steps_i), .lanes_o (lanes_o),
    .next_tweak_o (next_tweak_o), .err_o (err_o)
  );

  // Reference: full 128-bit shift, fold 0x87 on the bit that falls off.
  function automatic logic [127:0] ref_mul(logic [127:0] t, int k);
    logic [127:0] r;
    r = t;
    for (int i = 0; i < k; i++) begin
      r = {r[126:0], 1'b0} ^ (r[127] ? 128'h87 : 128'h0);
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge; results are read at the next.
  task automatic drive(logic ld, logic [127:0] tw, logic adv, logic [4:0] k);
    load_i = ld; load_tweak_i = tw; adv_i = adv; adv_steps_i = k;
    @(negedge clk);
    load_i = 1'b0; adv_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [127:0] z;
    z = '0;
    check("R1 tweak", next_tweak_o, z);
    check("R1 err", {127'b0, err_o}, z);
    for (int n = 0; n < NL; n++) check("R1 lane", lanes_o[n*128 +: 128], z);
  endtask

  task automatic t_load;
    drive(1'b1, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 1'b0, 5'd0);
    check("R2 load", next_tweak_o, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
  endtask

  task automatic t_single;
    drive(1'b1, 128'h8000_0000_0000_0000_8000_0000_0000_0000, 1'b0, 5'd0);
    drive(1'b0, '0, 1'b1, 5'd1);
    check("R4 carries", next_tweak_o, 128'h0000_0000_0000_0001_0000_0000_0000_0087);
    drive(1'b1, 128'h4000_0000_0000_0001_0000_0000_0000_0003, 1'b0, 5'd0);
    drive(1'b0, '0, 1'b1, 5'd1);
    check("R4 no carry", next_tweak_o, 128'h8000_0000_0000_0002_0000_0000_0000_0006);
  endtask

  task automatic t_multi(logic [127:0] seed, int k, string req);
    drive(1'b1, seed, 1'b0, 5'd0);
    drive(1'b0, '0, 1'b1, 5'(k));
    check(req, next_tweak_o, ref_mul(seed, k));
    check("R1 err quiet", {127'b0, err_o}, 128'h0);
  endtask

  task automatic t_lanes(logic [127:0] seed);
    drive(1'b1, seed, 1'b0, 5'd0);
    for (int n = 0; n < NL; n++) check("R7 lane", lanes_o[n*128 +: 128], ref_mul(seed, n));
  endtask

  task automatic t_group(logic [127:0] seed);
    logic [127:0] last;
    drive(1'b1, seed, 1'b0, 5'd0);
    last = lanes_o[(NL-1)*128 +: 128];
    drive(1'b0, '0, 1'b1, 5'(NL));
    check("R8 group", lanes_o[127:0], ref_mul(last, 1));
    check("R8 group tweak", next_tweak_o, ref_mul(seed, NL));
  endtask

  task automatic t_invalid(logic [4:0] k);
    drive(1'b1, 128'hdead_beef_0000_1111_2222_3333_4444_5555, 1'b0, 5'd0);
    drive(1'b0, '0, 1'b1, k);
    check("R6 err high", {127'b0, err_o}, 128'h1);
    check("R6 unchanged", next_tweak_o, 128'hdead_beef_0000_1111_2222_3333_4444_5555);
    drive(1'b0, '0, 1'b0, 5'd0);
    check("R6 err pulse", {127'b0, err_o}, 128'h0);
  endtask

  task automatic t_priority;
    drive(1'b1, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 1'b0, 5'd0);
    drive(1'b1, 128'haaaa_0000_bbbb_0000_cccc_0000_dddd_0000, 1'b1, 5'd3);
    check("R3 load wins", next_tweak_o, 128'haaaa_0000_bbbb_0000_cccc_0000_dddd_0000);
    check("R3 no err", {127'b0, err_o}, 128'h0);
    drive(1'b1, 128'h5, 1'b1, 5'd0);
    check("R3 load wins bad k", next_tweak_o, 128'h5);
    check("R3 no err bad k", {127'b0, err_o}, 128'h0);
  endtask

  task automatic t_idle;
    drive(1'b1, 128'hcafe_f00d_0000_0000_0000_0000_1234_5678, 1'b0, 5'd0);
    drive(1'b0, '0, 1'b0, 5'd9);
    drive(1'b0, '0, 1'b0, 5'd0);
    check("R10 hold", next_tweak_o, 128'hcafe_f00d_0000_0000_0000_0000_1234_5678);
    check("R10 err low", {127'b0, err_o}, 128'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_single();
    t_multi(128'h0f0f_1234_5678_9abc_def0_1357_9bdf_2468, 5, "R5 k5");
    t_multi(128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff, 16, "R9 all ones");
    t_multi(128'haaaa_aaaa_aaaa_aaaa_5555_5555_5555_5555, 13, "R9 alt");
    t_multi(128'hfe00_0000_0000_0001_ff80_0000_0000_0000, 7, "R9 dense top");
    t_multi(128'h8000_0000_0000_0000_0000_0000_0000_0000, 16, "R9 msb");
    t_lanes(128'hffff_0000_ffff_0000_8000_0000_0000_0001);
    t_lanes(128'h0123_4567_89ab_cdef_0011_2233_4455_6677);
    t_group(128'hf000_0000_0000_0000_f000_0000_0000_0000);
    t_invalid(5'd0);
    t_invalid(5'd17);
    t_invalid(5'd31);
    t_priority();
    t_idle();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule